// File: doc/BRIEF.md
# Center-Aligned Complementary PWM with Buffered Duty Transfer

This block drives a pair of complementary PWM pins from two triangle counters. Counter 1 rises from 0 to the period value and falls back to 0. Counter 2 runs the same triangle, but starts a programmable number of enabled cycles later. The offset between the two counters forms the dead band: a pin is active only when both counters agree on its side of the compare value, so one pin cannot turn on until both counters have crossed the compare value.

Software never writes the compare value directly. It writes a duty buffer, and the block copies the buffer into the compare register at a transfer event. A 2-bit select field chooses that event. Two cases override the select field:

- While the buffer holds zero, the copy happens at the peak of counter 1.
- When the buffer goes from zero to a value below the period, the first copy after that write also happens at the peak of counter 1.

All registers sit behind a single write port. Registers other than the buffer take effect on the next clock.

Top module: `cpwm_dual`

## Requirements
- R1: While reset is held and after its release, the compare value is 0, both counters are 0 and rising, the buffer is 0 and both polarity bits are 1. The pins therefore show out_norm=0 and out_cntr=1.
- R2: On every enabled cycle, counter 1 steps toward the period value m while rising. It reverses at m, falls to 0 and reverses again, giving the sequence 0,1,..,m,..,1,0,1. If m is lowered below the counter while it is rising, it turns down at once.
- R3: Counter 2 follows the same stepping rule. It starts after the number of enabled cycles since reset reaches the dead-time register, and once started it keeps running.
- R4: The normal-phase function is active when both counters are below the compare value. The counter-phase function is active when both counters are at or above it. The two are never active together.
- R5: Polarity register bit 0 belongs to out_norm and bit 1 to out_cntr. A value of 1 drives the pin high when its function is active, and a value of 0 drives it low.
- R6: While the buffer holds 0, the buffer is copied to the compare register on the enabled cycle in which counter 1 is rising and at or above m, whatever the select field holds.
- R7: A buffer write of n with 1 ≤ n < m while the buffer holds 0 arms a one-shot. The next copy then happens at the counter-1 peak, and that copy clears the one-shot. A write of 0 also clears it. A write of n ≥ m from zero arms nothing.
- R8: Otherwise, the select field sets the copy event:
  - 00: counter 1 at 0 while falling
  - 01: counter-1 peak
  - 10: counter-2 underflow (counter 2 running, falling and at 0)
  - 11: counter-1 peak or counter-2 underflow
- R9: Write addresses are 0 period, 1 duty buffer, 2 dead time, 3 select (bits 1:0) and 4 polarity (bits 1:0). The compare register is loaded only from the buffer. A write in the same cycle as a copy leaves the old buffer value in the compare register.
- R10: While cnt_en is low, neither counter, the dead-time delay nor the compare register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count enable; one counter step per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select for the write |
| wr_data | input | CW | Write data |
| out_norm | output | 1 | Normal-phase PWM pin |
| out_cntr | output | 1 | Counter-phase PWM pin |

## Verification
The assertions check a set of rules on every cycle:
- The compare register can only take the previous buffer value.
- The compare register never moves while the buffer is zero and no counter-1 peak occurs.
- Nothing moves while the count enable is low.
- Counter 1 steps up by one while rising below the period.
- A zero compare value forces both pins to their fixed levels.

Only the bench scenarios can show when each transfer lands in time. They cover the one-shot after leaving zero, the four select codes, the dead-time start of counter 2 and the resulting edges on both pins. To do so, the bench follows a behavioural model through period changes, polarity flips and irregular enable patterns.

// File: rtl/cpwm_dual.sv
module cpwm_dual #(
  parameter int CW = 16,
  parameter logic [CW-1:0] RST_PERIOD = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic          out_norm,
  output logic          out_cntr
);
  localparam logic [2:0] A_PER  = 3'd0;
  localparam logic [2:0] A_BUF  = 3'd1;
  localparam logic [2:0] A_DEAD = 3'd2;
  localparam logic [2:0] A_SEL  = 3'd3;
  localparam logic [2:0] A_POL  = 3'd4;

  logic [CW-1:0] per, dbuf, dead, cmpv, c1, c2, dly;
  logic          up1, up2, run2, pend;
  logic [1:0]    tsel, pol;
  logic          go2, pk1, vl1, uf2, sel_evt, xfer, act_n, act_c, buf_wr;
  logic [CW:0]   nx1, nx2;

  function automatic logic [CW:0] tri_step(input logic up, input logic [CW-1:0] c,
                                           input logic [CW-1:0] lim);
    if (up) begin
      if (c >= lim) tri_step = {1'b0, (c == '0) ? c : c - 1'b1};
      else          tri_step = {1'b1, c + 1'b1};
    end else begin
      if (c == '0)  tri_step = {1'b1, (lim == '0) ? c : c + 1'b1};
      else          tri_step = {1'b0, c - 1'b1};
    end
  endfunction

  assign go2 = run2 || (dly == dead);
  assign pk1 = cnt_en && up1 && (c1 >= per);
  assign vl1 = cnt_en && !up1 && (c1 == '0);
  assign uf2 = cnt_en && go2 && !up2 && (c2 == '0);

  always_comb begin
    case (tsel)
      2'b00:   sel_evt = vl1;
      2'b01:   sel_evt = pk1;
      2'b10:   sel_evt = uf2;
      default: sel_evt = pk1 || uf2;
    endcase
  end

  assign xfer   = ((dbuf == '0) || pend) ? pk1 : sel_evt;
  assign buf_wr = wr_en && (wr_addr == A_BUF);
  assign nx1    = tri_step(up1, c1, per);
  assign nx2    = tri_step(up2, c2, per);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c1 <= '0; up1 <= 1'b1;
      c2 <= '0; up2 <= 1'b1;
      dly <= '0; run2 <= 1'b0;
    end else if (cnt_en) begin
      {up1, c1} <= nx1;
      if (go2) begin
        {up2, c2} <= nx2;
        run2 <= 1'b1;
      end else begin
        dly <= dly + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmpv <= '0;
      pend <= 1'b0;
    end else begin
      if (xfer) begin
        cmpv <= dbuf;
        pend <= 1'b0;
      end
      if (buf_wr) begin
        if ((dbuf == '0) && (wr_data != '0) && (wr_data < per)) pend <= 1'b1;
        else if (wr_data == '0) pend <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per  <= RST_PERIOD;
      dbuf <= '0;
      dead <= '0;
      tsel <= 2'b00;
      pol  <= 2'b11;
    end else if (wr_en) begin
      case (wr_addr)
        A_PER:   per  <= wr_data;
        A_BUF:   dbuf <= wr_data;
        A_DEAD:  dead <= wr_data;
        A_SEL:   tsel <= wr_data[1:0];
        A_POL:   pol  <= wr_data[1:0];
        default: ;
      endcase
    end
  end

  assign act_n    = (c1 < cmpv) && (c2 < cmpv);
  assign act_c    = (c1 >= cmpv) && (c2 >= cmpv);
  assign out_norm = act_n ~^ pol[0];
  assign out_cntr = act_c ~^ pol[1];
endmodule

module cpwm_dual_chk #(parameter int CW = 16) (
  input logic          clk,
  input logic          rst_n,
  input logic          cnt_en,
  input logic [CW-1:0] per,
  input logic [CW-1:0] dbuf,
  input logic [CW-1:0] cmpv,
  input logic [CW-1:0] c1,
  input logic [CW-1:0] c2,
  input logic [CW-1:0] dly,
  input logic          up1,
  input logic          pend,
  input logic [1:0]    pol,
  input logic          out_norm,
  input logic          out_cntr
);
  // R9
  xfer_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpv != $past(cmpv)) |-> (cmpv == $past(dbuf)));
  // R6
  zero_peak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((dbuf == '0) && !pend && !(cnt_en && up1 && (c1 >= per))) |=> $stable(cmpv));
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> ($stable(c1) && $stable(c2) && $stable(dly) && $stable(cmpv)));
  // R2
  rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && up1 && (c1 < per)) |=> (c1 == $past(c1) + 1'b1));
  // R5
  zero_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpv == '0) |-> ((out_norm == !pol[0]) && (out_cntr == pol[1])));
  // R4
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((out_norm == pol[0]) && (out_cntr == pol[1])));
endmodule

bind cpwm_dual cpwm_dual_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .per(per), .dbuf(dbuf), .cmpv(cmpv),
  .c1(c1), .c2(c2), .dly(dly), .up1(up1), .pend(pend), .pol(pol),
  .out_norm(out_norm), .out_cntr(out_cntr)
);

// File: tb/cpwm_dual_tb.sv
module cpwm_dual_tb;
  logic clk = 1'b0, rst_n = 1'b0, cnt_en = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic out_norm, out_cntr;
  int errors = 0, checks = 0, cyc = 0;
  bit cmp_on = 1'b0, done = 1'b0;
  string tag = "R1";

  int m_per, m_buf, m_dead, m_cmp, m_c1, m_c2, m_dly, m_sel, m_pol;
  bit m_up1, m_up2, m_run, m_pend;

  always #10 clk = ~clk;

  cpwm_dual u_dut (.clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .out_norm(out_norm), .out_cntr(out_cntr));

  task automatic chk(input string t, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", t, act, exp, cyc);
    end
  endtask

  task automatic step(inout int c, inout bit up, input int lim);
    if (up) begin
      if (c >= lim) begin up = 0; if (c > 0) c = c - 1; end
      else c = c + 1;
    end else begin
      if (c == 0) begin up = 1; if (lim > 0) c = 1; end
      else c = c - 1;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_per = 8; m_buf = 0; m_dead = 0; m_cmp = 0; m_c1 = 0; m_c2 = 0;
      m_dly = 0; m_sel = 0; m_pol = 3; m_up1 = 1; m_up2 = 1; m_run = 0; m_pend = 0;
    end else begin
      bit go, pk, vl, uf, se, xf;
      go = m_run || (m_dly == m_dead);
      pk = cnt_en && m_up1 && (m_c1 >= m_per);
      vl = cnt_en && !m_up1 && (m_c1 == 0);
      uf = cnt_en && go && !m_up2 && (m_c2 == 0);
      se = (m_sel == 0) ? vl : (m_sel == 1) ? pk : (m_sel == 2) ? uf : (pk || uf);
      xf = (m_buf == 0 || m_pend) ? pk : se;
      if (xf) begin m_cmp = m_buf; m_pend = 0; end
      if (cnt_en) begin
        step(m_c1, m_up1, m_per);
        if (go) begin step(m_c2, m_up2, m_per); m_run = 1; end
        else m_dly = m_dly + 1;
      end
      if (wr_en) begin
        if (wr_addr == 1) begin
          if (m_buf == 0 && wr_data != 0 && int'(wr_data) < m_per) m_pend = 1;
          else if (wr_data == 0) m_pend = 0;
        end
        case (wr_addr)
          3'd0: m_per = wr_data;
          3'd1: m_buf = wr_data;
          3'd2: m_dead = wr_data;
          3'd3: m_sel = wr_data & 3;
          3'd4: m_pol = wr_data & 3;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      bit an, ac;
      an = (m_c1 < m_cmp) && (m_c2 < m_cmp);
      ac = (m_c1 >= m_cmp) && (m_c2 >= m_cmp);
      chk({tag, " out_norm"}, out_norm, (an == m_pol[0]) ? 1 : 0);
      chk({tag, " out_cntr"}, out_cntr, (ac == m_pol[1]) ? 1 : 0);
      chk("R4 overlap", ((out_norm == m_pol[0]) && (out_cntr == m_pol[1])) ? 1 : 0, 0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[2:0]; wr_data = d[15:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n, input bit rnd);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cnt_en = rnd ? 1'($urandom_range(0, 1)) : 1'b1;
    end
    @(negedge clk);
    cnt_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 out_norm in reset", out_norm, 0);
    chk("R1 out_cntr in reset", out_cntr, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_norm after reset", out_norm, 0);
    chk("R1 out_cntr after reset", out_cntr, 1);
    cmp_on = 1'b1;
    tag = "R9";
    wr(0, 10); wr(2, 3); wr(3, 2);
    tag = "R7"; wr(1, 4);
    tag = "R3"; run(30, 0);
    tag = "R7"; run(40, 0);
    tag = "R8"; wr(1, 6); run(50, 0);
    wr(3, 0); wr(1, 3); run(50, 0);
    wr(3, 1); wr(1, 7); run(50, 0);
    wr(3, 3); wr(1, 5); run(50, 0);
    tag = "R6"; wr(3, 2); wr(1, 0); run(50, 0);
    chk("R6 normal pin idle at zero duty", out_norm, 0);
    tag = "R7"; wr(1, 12); run(50, 0);
    wr(1, 0); run(30, 0); wr(1, 2); run(50, 0);
    tag = "R2"; wr(0, 5); run(40, 0); wr(0, 1); run(20, 0); wr(0, 9); wr(1, 4); run(60, 0);
    tag = "R5"; wr(4, 0); run(40, 0); wr(4, 1); run(40, 0); wr(4, 2); run(40, 0); wr(4, 3);
    tag = "R10"; run(200, 1);
    wr(1, 8); run(100, 1);
    tag = "R9";
    @(negedge clk); cnt_en = 1'b1;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      wr_en = (i % 7 == 3); wr_addr = 3'd1; wr_data = 16'((i * 5) % 11);
    end
    @(negedge clk); wr_en = 1'b0; cnt_en = 1'b0;
    run(40, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule